// File: doc/BRIEF.md
# NAND Flash Opcode Sequencer

This block runs one NAND flash transaction from a 32-bit program word made of eight 4-bit opcodes. A host loads its side values: four command bytes, a column address, a block-and-page row address, a one-byte user address, a byte count, a 16-bit short-write value and a wait limit. It then pulses `start`. The sequencer copies the program word, runs the slots in order, and drives abstract flash strobes for command, address, data-write and data-read cycles. Each strobe marks one byte on `flash_dout` or `flash_din`.

Bulk transfers move bytes between the flash side and a simple page buffer port. The buffer returns `buf_rdata` combinationally for `buf_addr`, and takes a write whenever `buf_we` is high. Short transfers of one or two bytes use the short-data value instead. Four opcodes first wait for the ready/busy input, then act as a plain command or read opcode. A wait that runs too long aborts the transaction. A normal end raises a one-cycle `done`. An abort raises the `timeout` flag.

Top module: `nand_op_sequencer`

## Requirements
- R1: A `start` seen while idle copies `instr` and raises `busy` on the next edge. Slots then run strictly in order, from slot 0 in bits 31:28 down to slot 7 in bits 3:0.
- R2: Opcode 0x0 ends the sequence. If no 0x0 is met, the sequence ends after slot 7. At the end `busy` falls and `done` is high for exactly one cycle.
- R3: Opcodes 0x1, 0x2 and 0x3 produce address cycles. They issue COL_BYTES bytes of `col_addr`, ROW_BYTES bytes of `row_addr`, or the single byte `user_addr`, least significant byte first.
- R4: Opcodes 0x4 to 0x7 produce one command cycle each. They send byte 0 to 3 of `cmd_bytes`, where byte 0 is bits 31:24 and byte 3 is bits 7:0.
- R5: Opcode 0x8 makes `byte_cnt` data-write cycles that send `buf_rdata` for buffer addresses 0 upward. Opcode 0xA makes `byte_cnt` data-read cycles that write `flash_din` to buffer addresses 0 upward.
- R6: Opcode 0x9 writes one byte of `short_wdata`, or two bytes when `short_two` is 1, low byte first. Opcode 0xB reads the same number of bytes into `short_rdata`: the first byte goes to bits 7:0, the second to bits 15:8, and the upper byte is cleared on a one-byte read.
- R7: Opcodes 0xC, 0xD, 0xE and 0xF produce no strobe until `flash_rdy` has been sampled high. One cycle after that, they act as 0x4, 0x5, 0xA and 0xB respectively.
- R8: A bulk opcode (0x8, 0xA, 0xE) with `byte_cnt` of 0 produces no strobe and passes to the next slot after one cycle.
- R9: If `flash_rdy` stays low for `wait_limit`+1 consecutive cycles of a ready wait, the sequence aborts. `busy` falls, `timeout` is set and `done` stays low. `timeout` holds until the next accepted `start`.
- R10: A `start` pulse while `busy` is high is ignored. The running program continues unchanged.
- R11: At most one strobe is high in any cycle, and none is high while idle. `flash_dout` is 0 in cycles with no command, address or data-write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction |
| instr | input | 32 | Eight-slot opcode program |
| cmd_bytes | input | 32 | Four command bytes |
| col_addr | input | 8*COL_BYTES | Column address |
| row_addr | input | 8*ROW_BYTES | Block and page address |
| user_addr | input | 8 | User address byte |
| byte_cnt | input | CNT_W | Bulk transfer length |
| short_two | input | 1 | Short transfers use two bytes |
| short_wdata | input | 16 | Short write source |
| wait_limit | input | TMO_W | Ready-wait limit |
| flash_rdy | input | 1 | Flash ready (1) or busy (0) |
| flash_din | input | 8 | Byte from the flash |
| buf_rdata | input | 8 | Buffer read data |
| busy | output | 1 | Transaction running |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Last transaction aborted on a wait |
| cmd_cycle | output | 1 | Command byte strobe |
| addr_cycle | output | 1 | Address byte strobe |
| data_wr | output | 1 | Data write byte strobe |
| data_rd | output | 1 | Data read byte strobe |
| flash_dout | output | 8 | Byte to the flash |
| buf_addr | output | CNT_W | Buffer byte address |
| buf_we | output | 1 | Buffer write enable |
| buf_wdata | output | 8 | Buffer write data |
| short_rdata | output | 16 | Short read result |

## Verification
The assertions assume that the side values (`cmd_bytes`, addresses, `byte_cnt`, `short_two`, `short_wdata`, `wait_limit`) hold still while `busy` is high. Only the program word is copied at start. The stimulus changes these values only between transactions, with the sequencer idle. It also keeps `byte_cnt` inside the buffer modelled by the bench. `flash_rdy` and `flash_din` are the only inputs that change during a run. They are driven just after a clock edge, so every sampled value is stable.

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer #(
  parameter int CNT_W     = 8,
  parameter int TMO_W     = 16,
  parameter int COL_BYTES = 2,
  parameter int ROW_BYTES = 3,
  localparam int COL_W    = 8 * COL_BYTES,
  localparam int ROW_W    = 8 * ROW_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      instr,
  input  logic [31:0]      cmd_bytes,
  input  logic [COL_W-1:0] col_addr,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [7:0]       user_addr,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             short_two,
  input  logic [15:0]      short_wdata,
  input  logic [TMO_W-1:0] wait_limit,
  input  logic             flash_rdy,
  input  logic [7:0]       flash_din,
  input  logic [7:0]       buf_rdata,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  output logic             cmd_cycle,
  output logic             addr_cycle,
  output logic             data_wr,
  output logic             data_rd,
  output logic [7:0]       flash_dout,
  output logic [CNT_W-1:0] buf_addr,
  output logic             buf_we,
  output logic [7:0]       buf_wdata,
  output logic [15:0]      short_rdata
);

  logic [31:0]      prog;
  logic [2:0]       slot;
  logic [CNT_W-1:0] idx;
  logic             waited;
  logic [TMO_W-1:0] wcnt;

  logic [3:0]       op, eop;
  logic [CNT_W-1:0] len;
  logic [COL_W-1:0] col_sh;
  logic [ROW_W-1:0] row_sh;

  assign op  = prog[{~slot, 2'b00} +: 4];
  assign eop = (op[3] & op[2]) ? (op[1] ? {3'b101, op[0]} : {3'b010, op[0]}) : op;

  always_comb begin
    case (eop)
      4'h0:         len = '0;
      4'h1:         len = CNT_W'(COL_BYTES);
      4'h2:         len = CNT_W'(ROW_BYTES);
      4'h8, 4'hA:   len = byte_cnt;
      4'h9, 4'hB:   len = short_two ? CNT_W'(2) : CNT_W'(1);
      default:      len = CNT_W'(1);
    endcase
  end

  wire hold   = busy && op[3] && op[2] && !waited;
  wire run    = busy && !hold;
  wire act    = run && (eop != 4'h0) && (len != '0);
  wire adv    = run && ((eop == 4'h0) || (len == '0) || (idx == len - 1'b1));
  wire finish = run && ((eop == 4'h0) || (adv && slot == 3'd7));
  wire abort  = hold && !flash_rdy && (wcnt == wait_limit);

  assign cmd_cycle  = act && (eop[3:2] == 2'b01);
  assign addr_cycle = act && (eop[3:2] == 2'b00);
  assign data_wr    = act && (eop[3:1] == 3'b100);
  assign data_rd    = act && (eop[3:1] == 3'b101);
  assign buf_addr   = idx;
  assign buf_we     = data_rd && !eop[0];
  assign buf_wdata  = flash_din;
  assign col_sh     = col_addr >> {idx, 3'b000};
  assign row_sh     = row_addr >> {idx, 3'b000};

  always_comb begin
    flash_dout = 8'h00;
    if (cmd_cycle)
      flash_dout = cmd_bytes[{~eop[1:0], 3'b000} +: 8];
    else if (addr_cycle)
      case (eop[1:0])
        2'd1:    flash_dout = col_sh[7:0];
        2'd2:    flash_dout = row_sh[7:0];
        default: flash_dout = user_addr;
      endcase
    else if (data_wr)
      flash_dout = eop[0] ? (idx[0] ? short_wdata[15:8] : short_wdata[7:0]) : buf_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; timeout <= 1'b0;
      prog <= '0; slot <= '0; idx <= '0; waited <= 1'b0; wcnt <= '0;
      short_rdata <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; prog <= instr; slot <= '0; idx <= '0;
          waited <= 1'b0; wcnt <= '0; timeout <= 1'b0;
        end
      end else if (hold) begin
        if (flash_rdy) waited <= 1'b1;
        else if (abort) begin
          busy <= 1'b0; timeout <= 1'b1;
        end else wcnt <= wcnt + 1'b1;
      end else begin
        if (data_rd && eop[0]) begin
          if (idx == '0) short_rdata <= {8'h00, flash_din};
          else short_rdata[15:8] <= flash_din;
        end
        if (finish) begin
          busy <= 1'b0; done <= 1'b1;
        end else if (adv) begin
          slot <= slot + 1'b1; idx <= '0; waited <= 1'b0; wcnt <= '0;
        end else idx <= idx + 1'b1;
      end
    end
  end

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_cycle, addr_cycle, data_wr, data_rd}));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(cmd_cycle || addr_cycle || data_wr || data_rd || buf_we));
  assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_timeout_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (!busy && !done));
  assert_start_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_buf_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> data_rd);

endmodule

// File: tb/nand_op_sequencer_bench.sv
module nand_op_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8, TMO_W = 16, COL_BYTES = 2, ROW_BYTES = 3;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] instr = 0, cmd_bytes = 32'hA1B2C3D4;
  logic [8*COL_BYTES-1:0] col_addr = 16'h3412;
  logic [8*ROW_BYTES-1:0] row_addr = 24'h675645;
  logic [7:0] user_addr = 8'h9E;
  logic [CNT_W-1:0] byte_cnt = 3;
  logic short_two = 0;
  logic [15:0] short_wdata = 16'hBEEF;
  logic [TMO_W-1:0] wait_limit = 20;
  logic flash_rdy = 1;
  logic [7:0] flash_din = 8'h11;
  logic [7:0] buf_rdata;
  logic busy, done, timeout, cmd_cycle, addr_cycle, data_wr, data_rd, buf_we;
  logic [7:0] flash_dout, buf_wdata;
  logic [CNT_W-1:0] buf_addr;
  logic [15:0] short_rdata;

  logic [7:0] bmem [256];
  logic [7:0] em [256];
  int checks = 0, fails = 0, cyc = 0;

  nand_op_sequencer #(.CNT_W(CNT_W), .TMO_W(TMO_W), .COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES))
  u_nand_op_sequencer (.clk, .rst_n, .start, .instr, .cmd_bytes, .col_addr, .row_addr, .user_addr,
    .byte_cnt, .short_two, .short_wdata, .wait_limit, .flash_rdy, .flash_din, .buf_rdata,
    .busy, .done, .timeout, .cmd_cycle, .addr_cycle, .data_wr, .data_rd, .flash_dout,
    .buf_addr, .buf_we, .buf_wdata, .short_rdata);

  always #(CLK_PERIOD/2) clk = ~clk;
  assign buf_rdata = bmem[buf_addr];
  always @(posedge clk) begin
    if (buf_we) bmem[buf_addr] <= buf_wdata;
    flash_din <= flash_din + 8'h35;
    cyc <= cyc + 1;
  end

  // reference model
  int m_ops[$];
  bit m_busy = 0, m_done = 0, m_to = 0, m_waited = 0;
  int m_slot = 0, m_idx = 0, m_wcnt = 0;
  logic [15:0] m_sreg = 0;

  function automatic int eff(int op);
    case (op) 12: return 4; 13: return 5; 14: return 10; 15: return 11; default: return op; endcase
  endfunction
  function automatic int mlen(int e);
    if (e == 0) return 0;
    if (e == 1) return COL_BYTES;
    if (e == 2) return ROW_BYTES;
    if (e == 8 || e == 10) return int'(byte_cnt);
    if (e == 9 || e == 11) return short_two ? 2 : 1;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_to = 0; m_sreg = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_ops.delete();
          for (int i = 0; i < 8; i++) m_ops.push_back(int'(instr[31-4*i -: 4]));
          m_busy = 1; m_slot = 0; m_idx = 0; m_waited = 0; m_wcnt = 0; m_to = 0;
        end
      end else begin
        int op, e, l;
        op = m_ops[m_slot]; e = eff(op);
        if (op >= 12 && !m_waited) begin
          if (flash_rdy) m_waited = 1;
          else if (m_wcnt == int'(wait_limit)) begin m_busy = 0; m_to = 1; end
          else m_wcnt++;
        end else if (e == 0) begin
          m_busy = 0; m_done = 1;
        end else begin
          l = mlen(e);
          if (l > 0 && e == 10) em[m_idx] = flash_din;
          if (l > 0 && e == 11) m_sreg = (m_idx == 0) ? {8'h00, flash_din} : {flash_din, m_sreg[7:0]};
          if (l == 0 || m_idx == l - 1) begin
            if (m_slot == 7) begin m_busy = 0; m_done = 1; end
            else begin m_slot++; m_idx = 0; m_waited = 0; m_wcnt = 0; end
          end else m_idx++;
        end
      end
    end
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison at the falling edge
  always @(negedge clk) if (rst_n) begin
    int op, e, l;
    bit act;
    logic [7:0] xd;
    op = m_busy ? m_ops[m_slot] : 0; e = eff(op); l = mlen(e);
    act = m_busy && !(op >= 12 && !m_waited) && e != 0 && l > 0;
    xd = 0;
    if (act && e >= 4 && e <= 7) xd = 8'(cmd_bytes >> (8 * (7 - e)));
    if (act && e == 1) xd = 8'(col_addr >> (8 * m_idx));
    if (act && e == 2) xd = 8'(row_addr >> (8 * m_idx));
    if (act && e == 3) xd = user_addr;
    if (act && e == 8) xd = bmem[m_idx];
    if (act && e == 9) xd = 8'(short_wdata >> (8 * m_idx));
    check(busy == m_busy, "R1/R10 busy", busy, m_busy);
    check(done == m_done, "R2 done", done, m_done);
    check(timeout == m_to, "R9 timeout", timeout, m_to);
    check(cmd_cycle == (act && e >= 4 && e <= 7), "R4/R7 cmd_cycle", cmd_cycle, act && e >= 4 && e <= 7);
    check(addr_cycle == (act && e >= 1 && e <= 3), "R3 addr_cycle", addr_cycle, act && e >= 1 && e <= 3);
    check(data_wr == (act && (e == 8 || e == 9)), "R5/R6/R8 data_wr", data_wr, act && (e == 8 || e == 9));
    check(data_rd == (act && (e == 10 || e == 11)), "R5/R6/R7 data_rd", data_rd, act && (e == 10 || e == 11));
    check(flash_dout == xd, "R11 flash_dout", flash_dout, xd);
    check(buf_we == (act && e == 10), "R5 buf_we", buf_we, act && e == 10);
    if (act && (e == 8 || e == 10)) check(buf_addr == CNT_W'(m_idx), "R5 buf_addr", buf_addr, m_idx);
    if (buf_we) check(buf_wdata == flash_din, "R5 buf_wdata", buf_wdata, flash_din);
    check(short_rdata == m_sreg, "R6 short_rdata", short_rdata, m_sreg);
  end

  task automatic go(input logic [31:0] prg);
    @(posedge clk); #1 instr = prg; start = 1;
    @(posedge clk); #1 start = 0;
    while (busy) @(posedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin bmem[i] = 8'(i * 7 + 1); em[i] = 8'(i * 7 + 1); end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !timeout && !cmd_cycle && flash_dout == 0, "R11 reset state", busy, 0);
    // R1 R3 R4 R6: mixed program ending on a no-op (R2)
    short_two = 0;
    go(32'h41239506);
    // R2 R5 R6: all eight slots, two-byte short ops
    short_two = 1; byte_cnt = 3;
    go(32'h8AB67491);
    // R7: fused wait opcodes with late ready
    flash_rdy = 0;
    fork
      go(32'hCEFD0000);
      begin repeat (5) @(posedge clk); #1 flash_rdy = 1; end
    join
    // R8: zero byte count
    byte_cnt = 0;
    go(32'h8AE90000);
    // R9: timeout abort
    byte_cnt = 4; wait_limit = 5; flash_rdy = 0;
    go(32'hC4000000);
    check(timeout == 1, "R9 timeout held", timeout, 1);
    flash_rdy = 1;
    // R9 cleared by next start; R10 start ignored while busy
    byte_cnt = 10;
    fork
      go(32'hA8000000);
      begin repeat (4) @(posedge clk); #1 instr = 32'h12345678; start = 1; @(posedge clk); #1 start = 0; end
    join
    check(timeout == 0, "R9 timeout cleared", timeout, 0);
    for (int i = 0; i < 16; i++) check(bmem[i] == em[i], "R5 buffer contents", bmem[i], em[i]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule